// File: doc/BRIEF.md
# Per-Sample Coding Mode Controller

This block decides, once per sample of a single voice channel, which coding rate and mode the codec datapath next to it must use. It watches the channel's frame sync. When the sync pulse begins, it takes a snapshot of the channel configuration. In software mode that is the control word. In hardware mode it is the strap and select pins. When the sync pulse ends, it publishes the effective settings for the new sample and gives a one-cycle update strobe. The settings are the rate (32, 24 or 16 kbps), the bits per code word, the direction, the companding law, the bypass and idle qualifiers, and the fill value for the spare bit after the LSB of a 24 kbps word.

The rate can change between any two samples without a reset, because the snapshot is taken again for every sample. A sync pulse two or more clocks wide marks a signalling frame. If the selected rate is 32 kbps, that one frame is coded at 24 kbps, so that the LSB is free for signalling. In hardware mode, two strap pins choose the rate. Both low gives 32 kbps. Both high through reset gives 16 kbps. Low through reset and raised afterwards gives 24 kbps.

Top module: `adpcm_mode_ctrl`

## Requirements
- R1: During and after reset, before the first update, the outputs read: eff_rate = 0 (32 kbps), code_bits = 4, idle = 1, and mode_upd, sig_frame, bypass, compress, mu_law and fill_bit all 0.
- R2: In software mode the algorithm field cfg_word[2:0] = {sel2, sel1, sel0} decodes as follows: 3'b000 gives 32 kbps (eff_rate 0, code_bits 4), 3'b111 gives 24 kbps (eff_rate 1, code_bits 3), and 3'b101 gives 16 kbps (eff_rate 2, code_bits 2). Every other code gives 32 kbps.
- R3: The configuration is sampled on the first clock edge at which fsync is seen high. A cfg_word change after that edge does not affect the current sample and applies from the next one. mode_upd pulses for exactly one cycle; it is visible in the cycle after the first edge that sees fsync low again. The outputs change only together with mode_upd.
- R4: If fsync is high for two or more consecutive edges and the selected rate is 32 kbps, that sample reports eff_rate 1, code_bits 3 and sig_frame 1. The next sample with a one-clock sync returns to the selected rate with sig_frame 0.
- R5: A wide sync while the selected rate is 24 or 16 kbps leaves the rate unchanged and reports sig_frame 0.
- R6: In hardware mode (sw_mode = 0) the straps count as high only when strap_a and strap_b are both 1. Straps low give 32 kbps. Straps high now and high at the last reset clock give 16 kbps. Straps high now but low at the last reset clock give 24 kbps. compress, mu_law and idle follow hw_compress, hw_mu_law and hw_idle, and bypass is 0.
- R7: fill_bit is 1 only when all of these hold: software mode, selected algorithm 24 kbps (not the signalling override), compress = 1, and neither bypass nor idle. Otherwise it is 0.
- R8: In software mode the fields are cfg_word[3] = compress (1 = encode), cfg_word[4] = mu-law (1) versus A-law (0), cfg_word[5] = bypass request and cfg_word[6] = idle. The bypass output is the bypass request AND NOT idle. compress, mu_law and idle pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, sampled on each rising edge |
| sw_mode | input | 1 | 1 = software configuration, 0 = hardware straps |
| cfg_word | input | 7 | Software control word (fields in R2, R8) |
| strap_a | input | 1 | Rate strap pin A (hardware mode) |
| strap_b | input | 1 | Rate strap pin B (hardware mode) |
| hw_compress | input | 1 | Hardware-mode direction, 1 = encode |
| hw_mu_law | input | 1 | Hardware-mode law, 1 = mu-law |
| hw_idle | input | 1 | Hardware-mode idle select |
| mode_upd | output | 1 | One-cycle strobe: new per-sample settings |
| eff_rate | output | 2 | Effective rate: 0 = 32, 1 = 24, 2 = 16 kbps |
| code_bits | output | 3 | Bits per code word at that rate |
| sig_frame | output | 1 | Sample is a signalling frame |
| compress | output | 1 | 1 = encode, 0 = decode |
| mu_law | output | 1 | 1 = mu-law, 0 = A-law |
| bypass | output | 1 | Pass the data through uncoded |
| idle | output | 1 | Channel idled |
| fill_bit | output | 1 | Value of the bit after the LSB of a 24 kbps word |

## Verification
The bench changes cfg_word in the cycle just after the capture edge. A design that samples at the end of the sync would then code the current sample with the new word, one sample early. Wide syncs go in at 32 kbps and at 16 kbps, each followed by a normal sync. A design that lets the override stick would stay at 24 kbps, and one that ignores the selected rate would drop 16 kbps to 24. Hardware mode is run after resets with the straps low and with them high, and with only one strap high. This catches a design that confuses the 24 and 16 kbps strap timing or treats a single strap as enough. Bypass with idle set, undefined algorithm codes, and 24 kbps in expand mode and in hardware mode all target fill and bypass qualifiers that are set too freely.

// File: rtl/adpcm_mode_pkg.sv
`timescale 1ns/1ps
package adpcm_mode_pkg;

  typedef enum logic [1:0] {
    RATE_32K = 2'd0,
    RATE_24K = 2'd1,
    RATE_16K = 2'd2
  } rate_e;

  // Per-sample configuration snapshot
  typedef struct packed {
    logic  from_sw;
    rate_e sel_rate;
    logic  enc;
    logic  mu;
    logic  byp_req;
    logic  idl;
  } snap_t;

  // Algorithm field {sel2,sel1,sel0}; unlisted codes fall back to 32 kbps
  function automatic rate_e decode_alg(input logic [2:0] sel);
    case (sel)
      3'b111:  return RATE_24K;
      3'b101:  return RATE_16K;
      default: return RATE_32K;
    endcase
  endfunction

  // Hardware straps: level now plus level held at the end of reset
  function automatic rate_e strap_rate(input logic hi_now, input logic hi_at_rst);
    if (!hi_now)   return RATE_32K;
    if (hi_at_rst) return RATE_16K;
    return RATE_24K;
  endfunction

  // Signalling frames borrow the LSB: 32 kbps drops to 24 kbps
  function automatic rate_e apply_signalling(input rate_e r, input logic wide);
    return (wide && r == RATE_32K) ? RATE_24K : r;
  endfunction

  function automatic logic [2:0] rate_bits(input rate_e r);
    case (r)
      RATE_24K: return 3'd3;
      RATE_16K: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fsync_width_mon.sv
`timescale 1ns/1ps
module fsync_width_mon #(
  parameter int WID_W     = 3,
  parameter int SIG_WIDTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic fs_rise,
  output logic fs_fall,
  output logic fs_wide
);
  localparam logic [WID_W-1:0] CNT_MAX = {WID_W{1'b1}};
  localparam logic [WID_W-1:0] SIG_MIN = WID_W'(SIG_WIDTH);

  logic             fs_d;
  logic [WID_W-1:0] hi_cnt;

  assign fs_rise = fsync & ~fs_d;
  assign fs_fall = ~fsync & fs_d;
  assign fs_wide = fs_fall & (hi_cnt >= SIG_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      fs_d <= fsync;
      if (fs_rise)
        hi_cnt <= WID_W'(1);
      else if (fsync && hi_cnt != CNT_MAX)
        hi_cnt <= hi_cnt + WID_W'(1);
    end
  end

  // R4
  wide_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_wide |-> ($past(fsync) && $past(fsync, 2)));

endmodule

// File: rtl/strap_rate_sel.sv
`timescale 1ns/1ps
module strap_rate_sel
  import adpcm_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strap_a,
  input  logic  strap_b,
  output rate_e hw_rate
);
  logic strap_hi;
  logic hi_at_rst;

  assign strap_hi = strap_a & strap_b;

  // Tracks the strap level while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) hi_at_rst <= strap_hi;
  end

  assign hw_rate = strap_rate(strap_hi, hi_at_rst);

  // R6
  strap_24_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rate == RATE_24K) |-> (strap_a && strap_b));

endmodule

// File: rtl/cfg_snapshot.sv
`timescale 1ns/1ps
module cfg_snapshot
  import adpcm_mode_pkg::*;
#(
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             sw_mode,
  input  logic [CFG_W-1:0] cfg_word,
  input  rate_e            hw_rate,
  input  logic             hw_compress,
  input  logic             hw_mu_law,
  input  logic             hw_idle,
  output snap_t            snap
);
  localparam int ENC_B = 3;
  localparam int MU_B  = 4;
  localparam int BYP_B = 5;
  localparam int IDL_B = 6;

  snap_t next_snap;

  always_comb begin
    if (sw_mode) begin
      next_snap.from_sw  = 1'b1;
      next_snap.sel_rate = decode_alg(cfg_word[2:0]);
      next_snap.enc      = cfg_word[ENC_B];
      next_snap.mu       = cfg_word[MU_B];
      next_snap.byp_req  = cfg_word[BYP_B];
      next_snap.idl      = cfg_word[IDL_B];
    end else begin
      next_snap.from_sw  = 1'b0;
      next_snap.sel_rate = hw_rate;
      next_snap.enc      = hw_compress;
      next_snap.mu       = hw_mu_law;
      next_snap.byp_req  = 1'b0;
      next_snap.idl      = hw_idle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '{from_sw: 1'b0, sel_rate: RATE_32K, enc: 1'b0, mu: 1'b0,
                byp_req: 1'b0, idl: 1'b1};
    end else if (capture) begin
      snap <= next_snap;
    end
  end

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(snap));

endmodule

// File: rtl/adpcm_mode_ctrl.sv
`timescale 1ns/1ps
module adpcm_mode_ctrl
  import adpcm_mode_pkg::*;
#(
  parameter int CFG_W     = 7,
  parameter int WID_W     = 3,
  parameter int SIG_WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             sw_mode,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             strap_a,
  input  logic             strap_b,
  input  logic             hw_compress,
  input  logic             hw_mu_law,
  input  logic             hw_idle,
  output logic             mode_upd,
  output logic [1:0]       eff_rate,
  output logic [2:0]       code_bits,
  output logic             sig_frame,
  output logic             compress,
  output logic             mu_law,
  output logic             bypass,
  output logic             idle,
  output logic             fill_bit
);
  // Named internal events
  logic  smp_start;
  logic  smp_commit;
  logic  smp_wide;
  rate_e hw_rate;
  snap_t snap;
  rate_e next_rate;
  logic  next_byp;
  logic  next_fill;

  fsync_width_mon #(.WID_W(WID_W), .SIG_WIDTH(SIG_WIDTH)) u_fsmon (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .fs_rise(smp_start), .fs_fall(smp_commit), .fs_wide(smp_wide)
  );

  strap_rate_sel u_strap (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .hw_rate(hw_rate)
  );

  cfg_snapshot #(.CFG_W(CFG_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(smp_start), .sw_mode(sw_mode),
    .cfg_word(cfg_word), .hw_rate(hw_rate), .hw_compress(hw_compress),
    .hw_mu_law(hw_mu_law), .hw_idle(hw_idle), .snap(snap)
  );

  always_comb begin
    next_rate = apply_signalling(snap.sel_rate, smp_wide);
    next_byp  = snap.byp_req & ~snap.idl;
    next_fill = snap.from_sw & (snap.sel_rate == RATE_24K) & snap.enc
              & ~next_byp & ~snap.idl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_upd  <= 1'b0;
      eff_rate  <= RATE_32K;
      code_bits <= rate_bits(RATE_32K);
      sig_frame <= 1'b0;
      compress  <= 1'b0;
      mu_law    <= 1'b0;
      bypass    <= 1'b0;
      idle      <= 1'b1;
      fill_bit  <= 1'b0;
    end else begin
      mode_upd <= smp_commit;
      if (smp_commit) begin
        eff_rate  <= next_rate;
        code_bits <= rate_bits(next_rate);
        sig_frame <= smp_wide & (snap.sel_rate == RATE_32K);
        compress  <= snap.enc;
        mu_law    <= snap.mu;
        bypass    <= next_byp;
        idle      <= snap.idl;
        fill_bit  <= next_fill;
      end
    end
  end

  // R3
  upd_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd |-> (!$past(fsync) && $past(fsync, 2)));

  // R3
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_upd |-> $stable({eff_rate, code_bits, sig_frame, compress, mu_law,
                           bypass, idle, fill_bit}));

  // R4
  sig_is_24k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_frame |-> (eff_rate == 2'd1 && code_bits == 3'd3));

  // R8
  bypass_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass && idle));

  // R7
  fill_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bit |-> (eff_rate == 2'd1 && compress && !sig_frame && !bypass));

endmodule

// File: tb/adpcm_mode_ctrl_tb.sv
`timescale 1ns/1ps
module adpcm_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       sw_mode = 1'b1;
  logic [6:0] cfg_word = '0;
  logic       strap_a = 1'b0, strap_b = 1'b0;
  logic       hw_compress = 1'b0, hw_mu_law = 1'b0, hw_idle = 1'b0;
  logic       mode_upd, sig_frame, compress, mu_law, bypass, idle, fill_bit;
  logic [1:0] eff_rate;
  logic [2:0] code_bits;

  int n_chk = 0, n_err = 0;
  bit straps_hi_at_rst = 1'b0;

  typedef struct {
    logic [10:0] v;
    string       req;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  adpcm_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sw_mode(sw_mode),
    .cfg_word(cfg_word), .strap_a(strap_a), .strap_b(strap_b),
    .hw_compress(hw_compress), .hw_mu_law(hw_mu_law), .hw_idle(hw_idle),
    .mode_upd(mode_upd), .eff_rate(eff_rate), .code_bits(code_bits),
    .sig_frame(sig_frame), .compress(compress), .mu_law(mu_law),
    .bypass(bypass), .idle(idle), .fill_bit(fill_bit)
  );

  function automatic logic [10:0] observed();
    return {eff_rate, code_bits, sig_frame, compress, mu_law, bypass, idle, fill_bit};
  endfunction

  task automatic check(input bit ok, input string req, input logic [10:0] act,
                       input logic [10:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Independent model: returns {rate, bits, sig, enc, mu, byp, idle, fill}
  function automatic logic [10:0] model(input bit wide);
    int sel_kbps, eff_kbps;
    logic [1:0] rc;
    logic [2:0] nb;
    logic e, m, i, b, f, s;
    if (sw_mode) begin
      if (cfg_word[2:0] == 3'b111) sel_kbps = 24;
      else if (cfg_word[2:0] == 3'b101) sel_kbps = 16;
      else sel_kbps = 32;
      e = cfg_word[3]; m = cfg_word[4]; i = cfg_word[6];
      b = cfg_word[5] && !i;
    end else begin
      if (!(strap_a && strap_b)) sel_kbps = 32;
      else sel_kbps = straps_hi_at_rst ? 16 : 24;
      e = hw_compress; m = hw_mu_law; i = hw_idle; b = 1'b0;
    end
    s = wide && sel_kbps == 32;
    eff_kbps = s ? 24 : sel_kbps;
    rc = (eff_kbps == 32) ? 2'd0 : (eff_kbps == 24) ? 2'd1 : 2'd2;
    nb = 3'(eff_kbps / 8);
    f = sw_mode && sel_kbps == 24 && e && !b && !i;
    return {rc, nb, s, e, m, b, i, f};
  endfunction

  // Driver: pushes the expectation, then plays one sync pulse of width w.
  task automatic frame(input int w, input string req, input bit late = 0,
                       input logic [6:0] late_cfg = '0);
    exp_t it;
    it.v = model(w >= 2);
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk) fsync = 1'b1;
    for (int k = 1; k < w; k++) @(negedge clk);
    @(negedge clk);
    if (late) cfg_word = late_cfg;
    fsync = 1'b0;
    @(negedge clk);
    check(mode_upd === 1'b1, "R3 upd strobe", {10'd0, mode_upd}, 11'd1);
    @(negedge clk);
    check(mode_upd === 1'b0, "R3 upd one cycle", {10'd0, mode_upd}, 11'd0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares each update against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mode_upd) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected update", observed(), 11'd0);
      end else begin
        cur = sb_q.pop_front();
        check(observed() === cur.v, cur.req, observed(), cur.v);
      end
    end
  end

  task automatic do_reset(input logic sa, input logic sb);
    rst_n = 1'b0;
    strap_a = sa; strap_b = sb;
    straps_hi_at_rst = sa && sb;
    repeat (4) @(negedge clk);
    check(observed() === 11'b00_100_0000_1_0 && mode_upd === 1'b0,
          "R1 reset state", observed(), 11'b00_100_0000_1_0);
    rst_n = 1'b1;
    @(negedge clk);
    check(observed() === 11'b00_100_0000_1_0 && mode_upd === 1'b0,
          "R1 after release", observed(), 11'b00_100_0000_1_0);
  endtask

  initial begin
    #(5ns * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    sw_mode = 1'b1;
    do_reset(1'b0, 1'b0);

    // R2 decode in software mode: {idle,byp,mu,enc,alg}
    cfg_word = 7'b0_0_1_1_000; frame(1, "R2 alg 000 -> 32k");
    cfg_word = 7'b0_0_1_1_111; frame(1, "R2 R7 alg 111 encode -> 24k fill");
    cfg_word = 7'b0_0_0_0_111; frame(1, "R7 24k decode no fill");
    cfg_word = 7'b0_0_0_1_101; frame(1, "R2 alg 101 -> 16k");
    cfg_word = 7'b0_0_1_0_011; frame(1, "R2 undefined 011 -> 32k");
    cfg_word = 7'b0_0_0_1_110; frame(1, "R2 undefined 110 -> 32k");

    // R4 / R5 signalling frames
    cfg_word = 7'b0_0_1_1_000; frame(2, "R4 wide at 32k -> 24k sig");
    frame(1, "R4 normal sync back to 32k");
    frame(3, "R4 three-wide at 32k");
    cfg_word = 7'b0_0_1_1_101; frame(2, "R5 wide at 16k unchanged");
    cfg_word = 7'b0_0_1_1_111; frame(2, "R5 R7 wide at 24k keeps fill");

    // R8 bypass / idle
    cfg_word = 7'b0_1_1_1_111; frame(1, "R8 R7 bypass kills fill");
    cfg_word = 7'b1_1_0_1_111; frame(1, "R8 idle overrides bypass");
    cfg_word = 7'b1_0_1_1_000; frame(1, "R8 idle pass");

    // R3 late change after capture edge
    cfg_word = 7'b0_0_1_1_000;
    frame(1, "R3 late change ignored", 1'b1, 7'b0_0_0_0_101);
    frame(1, "R3 late change next sample");

    // R6 hardware mode, straps low through reset
    sw_mode = 1'b0;
    hw_compress = 1'b1; hw_mu_law = 1'b1; hw_idle = 1'b0;
    do_reset(1'b0, 1'b0);
    frame(1, "R6 straps low -> 32k");
    frame(2, "R6 R4 hw wide -> 24k sig");
    strap_a = 1'b1; frame(1, "R6 single strap -> 32k");
    strap_b = 1'b1; frame(1, "R6 R7 raised after reset -> 24k no fill");
    hw_idle = 1'b1; hw_compress = 1'b0; hw_mu_law = 1'b0;
    frame(1, "R6 hw idle and law");

    // R6 straps high through reset
    hw_idle = 1'b0; hw_compress = 1'b1;
    do_reset(1'b1, 1'b1);
    frame(1, "R6 straps high at reset -> 16k");
    frame(2, "R6 R5 wide at hw 16k");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R3 all updates seen", 11'(sb_q.size()), 11'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule